// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block sits between a serial deserializer and a processor bus. Each received character arrives with its error flags. The block stores the character and its flags together in a 16-entry first-in first-out queue. The bus side reads the oldest entry as one packed word and removes it with a pop strobe.

The block raises one interrupt line from three receive sources:
- the queue was overrun;
- the fill level reached a programmable threshold;
- the queue has held data for a programmed number of character times with no arrival and no read.

Each source has a status bit and a mask bit. A separate status bit reports that the queue holds data. The overrun status is sticky. Only a queue clear removes it, and that clear also discards the stored entries.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: After reset the queue is empty. All four status bits, the three mask bits and `irq` are 0. The threshold is 8 (half the depth) and the timeout limit is 1 character time.
- R2: Entries leave in arrival order. The read word packs bits 7:0 = byte, bit 8 = frame error, bit 9 = parity error, bit 10 = break, bit 11 = valid. Valid is 1 for every stored entry.
- R3: The queue holds 16 entries. An arrival while the queue is full is dropped, the stored entries are unchanged, and overrun status (`irq_status` bit 0) is set.
- R4: Overrun status survives pops and mask writes. Only a `fifo_clear` pulse resets it, and that pulse also empties the queue.
- R5: Threshold status (`irq_status` bit 1) equals (fill level >= threshold). The threshold is loaded from `cfg_thresh` on `cfg_wr`.
- R6: Timeout status (`irq_status` bit 2) sets when the queue is non-empty and the limit number of `char_tick` pulses have passed since the last accepted push or pop. Every push or pop restarts the count. A limit of 0 disables the timeout.
- R7: A pop clears the timeout status. A pop on an empty queue reads a word with valid = 0 and changes neither the level nor any later contents.
- R8: Not-empty status (`irq_status` bit 3) is 1 exactly when the queue holds at least one entry.
- R9: `irq` is the OR of status bits 2:0, each ANDed with the matching `irq_mask` bit. Not-empty status is not an interrupt source.
- R10: A mask write (`mask_wr`) loads `irq_mask` on the next cycle and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break detected on this character |
| rx_par_err | input | 1 | Parity error on this character |
| rx_frm_err | input | 1 | Frame error on this character |
| char_tick | input | 1 | One pulse per character time |
| rd_pop | input | 1 | Remove the head entry |
| rd_word | output | 12 | Head entry, packed as in R2; all zero when empty |
| fifo_clear | input | 1 | Empty the queue and clear overrun and timeout |
| cfg_wr | input | 1 | Load threshold and timeout limit |
| cfg_thresh | input | 5 | Threshold value |
| cfg_tmo | input | 4 | Timeout limit in character times |
| mask_wr | input | 1 | Load interrupt mask |
| mask_wdata | input | 3 | Mask value: bit 0 overrun, bit 1 threshold, bit 2 timeout |
| irq_mask | output | 3 | Current mask |
| irq_status | output | 4 | bit 0 overrun, bit 1 threshold, bit 2 timeout, bit 3 not-empty |
| irq | output | 1 | Interrupt request |

## Verification
A wrong fill level shows up one cycle after the push or pop that caused it, in three places: the not-empty bit, the threshold bit and the order or validity of popped words. Popping the whole queue exposes a lost or duplicated entry within a few cycles.

A corrupted timeout counter shows up as a timeout bit that sets one tick early or late, or that survives a pop. An overrun flag that leaks away is seen at the ports as soon as a pop or mask write happens before the clear.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue interrupt controller.
// Assumes an 8-bit character and four status flags per entry.
package rxq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = BYTE_W + 4;
    localparam int N_SRC  = 3;

    // Status bit positions in the interrupt status field.
    localparam int ST_OVR = 0;
    localparam int ST_THR = 1;
    localparam int ST_TMO = 2;
    localparam int ST_NE  = 3;

    // One queue entry: valid(11) break(10) parity(9) frame(8) byte(7:0).
    typedef struct packed {
        logic              valid;
        logic              brk;
        logic              par_err;
        logic              frm_err;
        logic [BYTE_W-1:0] data;
    } rxq_word_t;
endpackage

// File: rtl/rxq_fifo.sv
// Storage queue for received entries with a level counter.
// Assumes DEPTH is a power of two. A clear wins over push and pop.
// A push while full is dropped and reported on `drop`.
module rxq_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  rxq_pkg::rxq_word_t  push_word,
    input  logic                pop,
    input  logic                clear,
    output rxq_pkg::rxq_word_t  head_word,
    output logic [LVL_W-1:0]    level,
    output logic                empty,
    output logic                full,
    output logic                drop,
    output logic                acc_push,
    output logic                acc_pop
);
    rxq_pkg::rxq_word_t mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign empty    = (level == '0);
    assign full     = (level == LVL_W'(DEPTH));
    assign acc_push = push & ~full & ~clear;
    assign acc_pop  = pop & ~empty & ~clear;
    assign drop     = push & full & ~clear;

    // Write accepted entries into storage.
    always_ff @(posedge clk) begin
        if (acc_push) mem[wr_ptr] <= push_word;
    end

    // Advance pointers and track the level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (acc_push) wr_ptr <= wr_ptr + 1'b1;
            if (acc_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({acc_push, acc_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Present the head entry; all zero when nothing is stored.
    always_comb begin
        if (empty) head_word = '0;
        else       head_word = mem[rd_ptr];
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> (level == LVL_W'(DEPTH)));
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clear) |=> (level == '0));
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/rxq_timeout.sv
// Counts character times while the queue holds data.
// A restart (accepted push, accepted pop or clear) zeroes the count.
// The flag clears on any pop attempt or clear. A limit of 0 disables it.
module rxq_timeout #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             clear_flag,
    input  logic             empty,
    input  logic [TMO_W-1:0] limit,
    output logic             tmo_flag
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   cnt_next;
    logic             hit;

    assign cnt_next = {1'b0, cnt} + 1'b1;
    assign hit = tick && !empty && !restart && !tmo_flag &&
                 (limit != '0) && (cnt_next == {1'b0, limit});

    // Character-time counter, held at zero while empty.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || empty) cnt <= '0;
        else if (hit)                   cnt <= '0;
        else if (tick && !tmo_flag && limit != '0) cnt <= cnt_next[TMO_W-1:0];
    end

    // Sticky timeout flag, cleared by a read or a queue clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_flag) tmo_flag <= 1'b0;
        else if (hit)             tmo_flag <= 1'b1;
    end

    assert_tmo_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !tmo_flag);
    assert_tmo_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0 && !tmo_flag) |=> !tmo_flag);
    assert_tmo_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_flag |=> !tmo_flag);
endmodule

// File: rtl/rxq_irq_regs.sv
// Holds the configuration, the interrupt mask and the sticky overrun flag.
// It assembles the status field and drives the interrupt line.
// Assumes the level and flags come from the queue and the timeout blocks.
module rxq_irq_regs #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 4,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       drop,
    input  logic                       clear,
    input  logic                       cfg_wr,
    input  logic [LVL_W-1:0]           cfg_thresh,
    input  logic [TMO_W-1:0]           cfg_tmo,
    input  logic                       mask_wr,
    input  logic [rxq_pkg::N_SRC-1:0]  mask_wdata,
    input  logic [LVL_W-1:0]           level,
    input  logic                       empty,
    input  logic                       tmo_flag,
    output logic [TMO_W-1:0]           tmo_limit,
    output logic [rxq_pkg::N_SRC-1:0]  mask_q,
    output logic [rxq_pkg::N_SRC:0]    status,
    output logic                       irq
);
    logic [LVL_W-1:0] thresh_q;
    logic             ovr_q;

    // Configuration registers with half-depth and one-character defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q  <= LVL_W'(DEPTH / 2);
            tmo_limit <= TMO_W'(1);
        end else if (cfg_wr) begin
            thresh_q  <= cfg_thresh;
            tmo_limit <= cfg_tmo;
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Sticky overrun flag; only a queue clear removes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ovr_q <= 1'b0;
        else if (drop)       ovr_q <= 1'b1;
    end

    // Assemble the status field and the interrupt request.
    always_comb begin
        status                  = '0;
        status[rxq_pkg::ST_OVR] = ovr_q;
        status[rxq_pkg::ST_THR] = (level >= thresh_q);
        status[rxq_pkg::ST_TMO] = tmo_flag;
        status[rxq_pkg::ST_NE]  = ~empty;
        irq = |(status[rxq_pkg::N_SRC-1:0] & mask_q);
    end

    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clear) |=> ovr_q);
    assert_ovr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ovr_q);
    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clear) |=> ovr_q);
    assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(mask_wdata)));
    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/rxq_irq_ctrl.sv
// Top of the receive queue interrupt controller.
// It connects the storage queue, the timeout counter and the register block.
// Assumes rx_valid, char_tick, rd_pop and fifo_clear are one-cycle strobes
// synchronous to clk.
module rxq_irq_ctrl #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 4,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [rxq_pkg::BYTE_W-1:0] rx_data,
    input  logic                       rx_brk,
    input  logic                       rx_par_err,
    input  logic                       rx_frm_err,
    input  logic                       char_tick,
    input  logic                       rd_pop,
    output logic [rxq_pkg::WORD_W-1:0] rd_word,
    input  logic                       fifo_clear,
    input  logic                       cfg_wr,
    input  logic [LVL_W-1:0]           cfg_thresh,
    input  logic [TMO_W-1:0]           cfg_tmo,
    input  logic                       mask_wr,
    input  logic [rxq_pkg::N_SRC-1:0]  mask_wdata,
    output logic [rxq_pkg::N_SRC-1:0]  irq_mask,
    output logic [rxq_pkg::N_SRC:0]    irq_status,
    output logic                       irq
);
    rxq_pkg::rxq_word_t in_word;
    rxq_pkg::rxq_word_t head_word;
    logic [LVL_W-1:0]   level;
    logic               empty;
    logic               full;
    logic               drop;
    logic               acc_push;
    logic               acc_pop;
    logic               tmo_flag;
    logic [TMO_W-1:0]   tmo_limit;

    // Pack the incoming character with its flags.
    always_comb begin
        in_word.valid   = 1'b1;
        in_word.brk     = rx_brk;
        in_word.par_err = rx_par_err;
        in_word.frm_err = rx_frm_err;
        in_word.data    = rx_data;
    end

    assign rd_word = head_word;

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_word (in_word),
        .pop       (rd_pop),
        .clear     (fifo_clear),
        .head_word (head_word),
        .level     (level),
        .empty     (empty),
        .full      (full),
        .drop      (drop),
        .acc_push  (acc_push),
        .acc_pop   (acc_pop)
    );

    rxq_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (char_tick),
        .restart    (acc_push | acc_pop | fifo_clear),
        .clear_flag (rd_pop | fifo_clear),
        .empty      (empty),
        .limit      (tmo_limit),
        .tmo_flag   (tmo_flag)
    );

    rxq_irq_regs #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop       (drop),
        .clear      (fifo_clear),
        .cfg_wr     (cfg_wr),
        .cfg_thresh (cfg_thresh),
        .cfg_tmo    (cfg_tmo),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .level      (level),
        .empty      (empty),
        .tmo_flag   (tmo_flag),
        .tmo_limit  (tmo_limit),
        .mask_q     (irq_mask),
        .status     (irq_status),
        .irq        (irq)
    );

    assert_ne_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status[rxq_pkg::ST_NE] == rd_word[rxq_pkg::WORD_W-1]);
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !rd_pop && !fifo_clear) |=> $stable(rd_word));
endmodule

// File: tb/rxq_irq_ctrl_tb.sv
// Directed bench for the receive queue interrupt controller.
module rxq_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_brk, rx_par_err, rx_frm_err;
    logic [7:0]  rx_data;
    logic        char_tick, rd_pop, fifo_clear, cfg_wr, mask_wr;
    logic [11:0] rd_word;
    logic [4:0]  cfg_thresh;
    logic [3:0]  cfg_tmo;
    logic [2:0]  mask_wdata, irq_mask;
    logic [3:0]  irq_status;
    logic        irq;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rxq_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .char_tick(char_tick), .rd_pop(rd_pop), .rd_word(rd_word),
        .fifo_clear(fifo_clear), .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh),
        .cfg_tmo(cfg_tmo), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .irq_mask(irq_mask), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        #1;
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic b, input logic p, input logic f);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_par_err = p; rx_frm_err = f;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_word(output logic [11:0] w);
        @(negedge clk);
        #1 w = rd_word;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); char_tick = 1'b1;
            @(negedge clk); char_tick = 1'b0;
        end
    endtask

    task automatic qclear();
        @(negedge clk); fifo_clear = 1'b1;
        @(negedge clk); fifo_clear = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        @(negedge clk); mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic [4:0] th, input logic [3:0] to);
        @(negedge clk); cfg_wr = 1'b1; cfg_thresh = th; cfg_tmo = to;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", {28'd0, irq_status}, 32'h0);
        chk("R1 mask", {29'd0, irq_mask}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R8 empty word", {20'd0, rd_word}, 32'h0);
    endtask

    task automatic t_order();
        logic [11:0] w;
        push(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R8 not-empty", {31'd0, irq_status[3]}, 32'h1);
        push(8'h3C, 1'b0, 1'b1, 1'b0);
        push(8'h00, 1'b1, 1'b0, 1'b0);
        pop_word(w); chk("R2 word0", {20'd0, w}, 32'h9A5);
        pop_word(w); chk("R2 word1", {20'd0, w}, 32'hA3C);
        pop_word(w); chk("R2 word2", {20'd0, w}, 32'hC00);
        chk("R8 empty again", {31'd0, irq_status[3]}, 32'h0);
    endtask

    task automatic t_thresh();
        for (int i = 0; i < 7; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
        chk("R5 below default 8", {31'd0, irq_status[1]}, 32'h0);
        push(8'h07, 1'b0, 1'b0, 1'b0);
        chk("R1 R5 at default 8", {31'd0, irq_status[1]}, 32'h1);
        set_cfg(5'd10, 4'd1);
        chk("R5 below 10", {31'd0, irq_status[1]}, 32'h0);
        push(8'h08, 1'b0, 1'b0, 1'b0);
        push(8'h09, 1'b0, 1'b0, 1'b0);
        chk("R5 at 10", {31'd0, irq_status[1]}, 32'h1);
        qclear();
        chk("R4 clear empties", {28'd0, irq_status}, 32'h0);
        set_cfg(5'd8, 4'd1);
    endtask

    task automatic t_timeout();
        logic [11:0] w;
        set_mask(3'b100);
        push(8'h11, 1'b0, 1'b0, 1'b0);
        chk("R6 no tick yet", {31'd0, irq_status[2]}, 32'h0);
        tick(1);
        chk("R1 R6 default one char", {31'd0, irq_status[2]}, 32'h1);
        chk("R9 irq on timeout", {31'd0, irq}, 32'h1);
        pop_word(w);
        chk("R7 pop clears timeout", {31'd0, irq_status[2]}, 32'h0);
        set_cfg(5'd8, 4'd3);
        push(8'h22, 1'b0, 1'b0, 1'b0);
        tick(2);
        chk("R6 two of three", {31'd0, irq_status[2]}, 32'h0);
        push(8'h33, 1'b0, 1'b0, 1'b0);
        tick(2);
        chk("R6 restart on push", {31'd0, irq_status[2]}, 32'h0);
        tick(1);
        chk("R6 third tick", {31'd0, irq_status[2]}, 32'h1);
        pop_word(w);
        chk("R7 pop clears timeout 2", {31'd0, irq_status[2]}, 32'h0);
        set_cfg(5'd8, 4'd0);
        tick(5);
        chk("R6 disabled", {31'd0, irq_status[2]}, 32'h0);
        chk("R9 irq low", {31'd0, irq}, 32'h0);
        qclear();
        set_cfg(5'd8, 4'd1);
        set_mask(3'b000);
    endtask

    task automatic t_overrun();
        logic [11:0] w;
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        chk("R3 full no overrun", {31'd0, irq_status[0]}, 32'h0);
        push(8'hEE, 1'b0, 1'b0, 1'b0);
        chk("R3 overrun set", {31'd0, irq_status[0]}, 32'h1);
        set_mask(3'b000);
        chk("R10 mask write keeps overrun", {31'd0, irq_status[0]}, 32'h1);
        chk("R9 masked overrun", {31'd0, irq}, 32'h0);
        set_mask(3'b001);
        chk("R10 mask loaded", {29'd0, irq_mask}, 32'h1);
        chk("R9 unmasked overrun", {31'd0, irq}, 32'h1);
        set_mask(3'b010);
        chk("R9 other source off", {31'd0, irq}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            pop_word(w);
            chk("R3 kept entry", {20'd0, w}, {20'd0, 4'h8, 8'h40 + 8'(i)});
        end
        chk("R9 threshold gone", {31'd0, irq}, 32'h0);
        pop_word(w);
        chk("R3 dropped char absent", {20'd0, w}, 32'h0);
        chk("R4 overrun survives pops", {31'd0, irq_status[0]}, 32'h1);
        qclear();
        chk("R4 clear removes overrun", {31'd0, irq_status[0]}, 32'h0);
        set_mask(3'b000);
    endtask

    task automatic t_empty_read();
        logic [11:0] w;
        pop_word(w);
        chk("R7 empty read word", {20'd0, w}, 32'h0);
        chk("R7 empty read status", {28'd0, irq_status}, 32'h0);
        push(8'h5A, 1'b1, 1'b1, 1'b1);
        pop_word(w);
        chk("R7 R2 next entry intact", {20'd0, w}, 32'hF5A);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_brk = 1'b0;
        rx_par_err = 1'b0; rx_frm_err = 1'b0; char_tick = 1'b0; rd_pop = 1'b0;
        fifo_clear = 1'b0; cfg_wr = 1'b0; cfg_thresh = '0; cfg_tmo = '0;
        mask_wr = 1'b0; mask_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_thresh();
        t_timeout();
        t_overrun();
        t_empty_read();
        finish_up();
    end
endmodule